// File: doc/BRIEF.md
# Windowed Command and Status Front End

This block is the host-facing register front end of a network controller. The host changes controller state in one way only: it writes a 16-bit command word to one fixed offset. The top five bits of the word are an opcode and the low eleven bits are its argument. A read from that same offset returns a 16-bit status word. The offset does not depend on which register window is selected.

Through commands the host can:

- page between eight register windows;
- turn receive and transmit on or off;
- load an interrupt mask and a receive address filter;
- raise a software interrupt event;
- clear pending events bit by bit;
- return the whole front end to its reset state.

The datapath reports events on single-cycle pulse inputs. Each pulse latches a status bit, and the bit stays set until the host acknowledges it. The interrupt output is raised while any latched event is enabled in the mask. Each accepted command holds a busy flag for a fixed number of cycles. Commands that arrive while the flag is high are dropped.

Top module: `cmdwin_frontend`

## Requirements
- R1: After reset the status word reads 0x0000, irq is 0, the window is 0, receive and transmit are disabled, the receive filter is 0 and the interrupt mask is 0.
- R2: A command is taken only when host_wr is high and host_waddr equals 0x0E. A write to any other offset changes nothing.
- R3: Opcode 1 (bits 15:11 of the command word) sets the current window to argument bits 2:0. Status bits 15:13 report that window.
- R4: A read at offset 0x0E returns the status word. Bits 7:1 are the pending events for evt_in[6:0]. Bit 0 is 1 when any pending event is also enabled in the mask. Bit 12 is busy. Bits 11:8 read 0. A read at any other offset returns 0.
- R5: A pulse on evt_in[k] sets status bit k+1 on the next clock edge, and the bit stays set until it is cleared by a command.
- R6: Opcode 13 clears each status bit 1 to 7 whose argument bit in the same position is 1. If an event pulse arrives for a bit in the same cycle as its clear, the bit stays set.
- R7: Opcode 12 sets status bit 6.
- R8: Opcode 14 loads argument bits 7:1 as the mask for status bits 7:1. irq is 1 exactly when some status bit 1 to 7 is both pending and enabled in the mask.
- R9: Opcode 16 loads argument bits 3:0 into rx_filter. The bits mean: bit 0 own address, bit 1 multicast, bit 2 broadcast, bit 3 promiscuous.
- R10: Opcode 3 disables receive and opcode 4 enables it. Opcode 9 enables transmit and opcode 10 disables it.
- R11: Opcode 0 returns the window, the enables, the filter, the mask and all pending events to their reset values. An event pulse in the same cycle still sets its bit. The busy flag still starts.
- R12: An accepted command holds busy high for BUSY_CYCLES cycles, starting at the clock edge that accepts it. A command written while busy is high is dropped.
- R13: An opcode not named in R3 and R6 to R11 changes no state except starting busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_waddr | input | 4 | Host write byte offset |
| host_wdata | input | 16 | Host write data (command word) |
| host_raddr | input | 4 | Host read byte offset |
| host_rdata | output | 16 | Host read data |
| evt_in | input | 7 | Datapath event pulses, mapped to status bits 7:1 |
| irq | output | 1 | Interrupt request |
| cur_window | output | 3 | Currently selected register window |
| rx_enable | output | 1 | Receive enabled |
| tx_enable | output | 1 | Transmit enabled |
| rx_filter | output | 4 | Receive address filter |

## Verification
Almost all internal state is visible in the status word, so a wrong state shows at host_rdata on the clock edge after the cause:

- a wrong window appears in bits 15:13;
- a lost or stuck event appears in bits 7:1;
- a busy count of the wrong length appears in bit 12.

The mask is not read back directly. A mask error appears at irq and at status bit 0 on the first cycle in which an affected event is pending. The bench compares all outputs against a behavioural model on every cycle, so each such error is reported in the cycle it first appears.

// File: rtl/cmdwin_pkg.sv
package cmdwin_pkg;

  localparam logic [3:0] CMD_OFFSET = 4'hE;
  localparam int         ST_BUSY    = 12;
  localparam int         ST_WIN_LSB = 13;
  localparam int         EV_SWREQ   = 5;   // event index of status bit 6

  typedef enum logic [4:0] {
    OP_GRESET = 5'd0,
    OP_WINDOW = 5'd1,
    OP_RX_OFF = 5'd3,
    OP_RX_ON  = 5'd4,
    OP_TX_ON  = 5'd9,
    OP_TX_OFF = 5'd10,
    OP_SWREQ  = 5'd12,
    OP_ACK    = 5'd13,
    OP_MASK   = 5'd14,
    OP_FILTER = 5'd16
  } opcode_e;

  typedef struct packed {
    logic       greset;
    logic       window;
    logic       rx_off;
    logic       rx_on;
    logic       tx_on;
    logic       tx_off;
    logic       swreq;
    logic       ack;
    logic       mask;
    logic       filter;
    logic [7:0] arg;
  } cmd_strobe_t;

endpackage

// File: rtl/cmdwin_decode.sv
module cmdwin_decode
  import cmdwin_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic              busy,
  output logic              accept,
  output cmd_strobe_t       strobe
);

  logic    unused_arg_hi;
  opcode_e op;

  assign unused_arg_hi = ^wdata[10:8];
  assign op            = opcode_e'(wdata[15:11]);
  assign accept        = wr && (addr == ADDR_W'(CMD_OFFSET)) && !busy;

  always_comb begin
    strobe     = '0;
    strobe.arg = wdata[7:0];
    if (accept) begin
      case (op)
        OP_GRESET: strobe.greset = 1'b1;
        OP_WINDOW: strobe.window = 1'b1;
        OP_RX_OFF: strobe.rx_off = 1'b1;
        OP_RX_ON:  strobe.rx_on  = 1'b1;
        OP_TX_ON:  strobe.tx_on  = 1'b1;
        OP_TX_OFF: strobe.tx_off = 1'b1;
        OP_SWREQ:  strobe.swreq  = 1'b1;
        OP_ACK:    strobe.ack    = 1'b1;
        OP_MASK:   strobe.mask   = 1'b1;
        OP_FILTER: strobe.filter = 1'b1;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/cmdwin_busy.sv
module cmdwin_busy #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  output logic busy
);

  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = accept || (cnt_q != '0);
    if (accept) cnt_d = CNT_W'(CYCLES);
    else        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  a_r12_busy_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  a_r12_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);

endmodule

// File: rtl/cmdwin_events.sv
module cmdwin_events #(
  parameter int NUM_EVT = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] set_i,
  input  logic [NUM_EVT-1:0] clr_i,
  output logic [NUM_EVT-1:0] pend_o
);

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    logic pend_q, pend_d, pend_en;

    always_comb begin
      pend_en = set_i[i] || clr_i[i];
      pend_d  = set_i[i];          // the set input wins over a clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend_q <= 1'b0;
      else if (pend_en) pend_q <= pend_d;
    end

    assign pend_o[i] = pend_q;

    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> pend_o[i]);
    a_r5_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o[i] && !clr_i[i]) |=> pend_o[i]);
  end

endmodule

// File: rtl/cmdwin_frontend.sv
module cmdwin_frontend
  import cmdwin_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int NUM_EVT     = 7,
  parameter int WIN_W       = 3,
  parameter int FILT_W      = 4,
  parameter int BUSY_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic [ADDR_W-1:0]  host_waddr,
  input  logic [15:0]        host_wdata,
  input  logic [ADDR_W-1:0]  host_raddr,
  output logic [15:0]        host_rdata,
  input  logic [NUM_EVT-1:0] evt_in,
  output logic               irq,
  output logic [WIN_W-1:0]   cur_window,
  output logic               rx_enable,
  output logic               tx_enable,
  output logic [FILT_W-1:0]  rx_filter
);

  logic               busy, accept;
  cmd_strobe_t        stb;
  logic [NUM_EVT-1:0] pend, ev_set, ev_clr;

  logic [WIN_W-1:0]   win_q,  win_d;
  logic               rx_q,   rx_d;
  logic               tx_q,   tx_d;
  logic [FILT_W-1:0]  filt_q, filt_d;
  logic [NUM_EVT-1:0] mask_q, mask_d;
  logic               ctl_en;
  logic               latch_bit;

  cmdwin_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr     (host_wr),
    .addr   (host_waddr),
    .wdata  (host_wdata),
    .busy   (busy),
    .accept (accept),
    .strobe (stb)
  );

  cmdwin_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .busy   (busy)
  );

  always_comb begin
    ev_set = evt_in;
    ev_set[EV_SWREQ] = evt_in[EV_SWREQ] | stb.swreq;
    if (stb.greset)   ev_clr = '1;
    else if (stb.ack) ev_clr = stb.arg[NUM_EVT:1];
    else              ev_clr = '0;
  end

  cmdwin_events #(.NUM_EVT(NUM_EVT)) u_evt (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (ev_set),
    .clr_i  (ev_clr),
    .pend_o (pend)
  );

  // next state of the control registers
  always_comb begin
    ctl_en = accept;
    win_d  = win_q;
    rx_d   = rx_q;
    tx_d   = tx_q;
    filt_d = filt_q;
    mask_d = mask_q;
    if (stb.greset) begin
      win_d  = '0;
      rx_d   = 1'b0;
      tx_d   = 1'b0;
      filt_d = '0;
      mask_d = '0;
    end
    if (stb.window) win_d  = stb.arg[WIN_W-1:0];
    if (stb.rx_off) rx_d   = 1'b0;
    if (stb.rx_on)  rx_d   = 1'b1;
    if (stb.tx_on)  tx_d   = 1'b1;
    if (stb.tx_off) tx_d   = 1'b0;
    if (stb.filter) filt_d = stb.arg[FILT_W-1:0];
    if (stb.mask)   mask_d = stb.arg[NUM_EVT:1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      rx_q   <= 1'b0;
      tx_q   <= 1'b0;
      filt_q <= '0;
      mask_q <= '0;
    end else if (ctl_en) begin
      win_q  <= win_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      filt_q <= filt_d;
      mask_q <= mask_d;
    end
  end

  assign latch_bit  = |(pend & mask_q);
  assign irq        = latch_bit;
  assign cur_window = win_q;
  assign rx_enable  = rx_q;
  assign tx_enable  = tx_q;
  assign rx_filter  = filt_q;

  always_comb begin
    host_rdata = '0;
    if (host_raddr == ADDR_W'(CMD_OFFSET)) begin
      host_rdata[ST_WIN_LSB +: WIN_W] = win_q;
      host_rdata[ST_BUSY]             = busy;
      host_rdata[NUM_EVT:1]           = pend;
      host_rdata[0]                   = latch_bit;
    end
  end

  a_r3_window_load: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && host_wdata[15:11] == 5'd1) |=> cur_window == $past(host_wdata[WIN_W-1:0]));
  a_r11_global_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && host_wdata[15:11] == 5'd0) |=> (!rx_enable && !tx_enable && cur_window == '0 && rx_filter == '0));
  a_r2_offset_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (host_waddr != ADDR_W'(CMD_OFFSET)) |=> ($stable(cur_window) && $stable(rx_filter) && $stable(rx_enable)));
  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[11:8] == 4'h0);
  a_r8_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (host_raddr != ADDR_W'(CMD_OFFSET)) || (host_rdata[NUM_EVT:1] != '0));

endmodule

// File: tb/cmdwin_frontend_test.sv
`timescale 1ns/1ps
module cmdwin_frontend_test;

  localparam int CLK_PERIOD = 10;
  localparam int BUSY       = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [3:0]  host_waddr = 4'hE;
  logic [15:0] host_wdata = 16'h0;
  logic [3:0]  host_raddr = 4'hE;
  logic [15:0] host_rdata;
  logic [6:0]  evt_in = 7'h0;
  logic        irq;
  logic [2:0]  cur_window;
  logic        rx_enable, tx_enable;
  logic [3:0]  rx_filter;

  int    errors = 0;
  int    checks = 0;
  string req = "R1";

  // behavioural reference state
  int m_win, m_rx, m_tx, m_filt, m_mask, m_pend, m_busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdwin_frontend #(.BUSY_CYCLES(BUSY)) uut (
    .clk, .rst_n, .host_wr, .host_waddr, .host_wdata, .host_raddr,
    .host_rdata, .evt_in, .irq, .cur_window, .rx_enable, .tx_enable, .rx_filter
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_win = 0; m_rx = 0; m_tx = 0; m_filt = 0; m_mask = 0; m_pend = 0; m_busy = 0;
    end else begin
      int op, arg;
      bit take;
      take = host_wr && host_waddr == 4'hE && m_busy == 0;
      if (m_busy > 0) m_busy = m_busy - 1;
      if (take) begin
        m_busy = BUSY;
        op  = host_wdata >> 11;
        arg = host_wdata & 16'h07ff;
        case (op)
          0:  begin m_win = 0; m_rx = 0; m_tx = 0; m_filt = 0; m_mask = 0; m_pend = 0; end
          1:  m_win = arg % 8;
          3:  m_rx = 0;
          4:  m_rx = 1;
          9:  m_tx = 1;
          10: m_tx = 0;
          12: m_pend = m_pend | 32'h40;
          13: m_pend = m_pend & ~(arg & 32'hfe);
          14: m_mask = arg & 32'hfe;
          16: m_filt = arg % 16;
          default: ;
        endcase
      end
      m_pend = m_pend | (int'(evt_in) << 1);
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    int st;
    st = (m_win << 13) | ((m_busy != 0) << 12) | m_pend | (((m_pend & m_mask) != 0) ? 1 : 0);
    chk("rdata", int'(host_rdata), (host_raddr == 4'hE) ? st : 0);
    chk("irq", int'(irq), ((m_pend & m_mask) != 0) ? 1 : 0);
    chk("window", int'(cur_window), m_win);
    chk("rx_enable", int'(rx_enable), m_rx);
    chk("tx_enable", int'(tx_enable), m_tx);
    chk("rx_filter", int'(rx_filter), m_filt);
  end

  task automatic step(); @(posedge clk); #1; endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic cmd(input int op, input int arg, input logic [3:0] a = 4'hE, input int wait_n = BUSY);
    step();
    host_wr = 1'b1; host_waddr = a; host_wdata = 16'((op << 11) | (arg & 32'h7ff));
    step();
    host_wr = 1'b0; host_waddr = 4'hE;
    idle(wait_n);
  endtask

  task automatic pulse(input logic [6:0] e);
    step(); evt_in = e; step(); evt_in = 7'h0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    req = "R1"; idle(3); step(); rst_n = 1'b1; idle(2);

    req = "R3"; cmd(1, 5); cmd(1, 16'h7ff); cmd(1, 2);
    req = "R4"; host_raddr = 4'h2; idle(2); host_raddr = 4'hE;
    req = "R2"; cmd(1, 6, 4'hC); cmd(4, 0, 4'h0);

    req = "R5"; pulse(7'b0000101); idle(2);
    req = "R8"; cmd(14, 16'h0004); cmd(14, 16'h00fe); pulse(7'b1000000); idle(1);
    req = "R6"; cmd(13, 16'h0003); cmd(13, 16'h00fe);
    pulse(7'b0001010); step();
    host_wr = 1'b1; host_wdata = 16'h6800 | 16'h0006; evt_in = 7'b0000001;
    step(); host_wr = 1'b0; evt_in = 7'h0; idle(BUSY);
    req = "R7"; cmd(12, 0); cmd(13, 16'h0040); cmd(14, 16'h0040); cmd(12, 16'h7ff);

    req = "R9"; cmd(16, 16'h0005); cmd(16, 16'h07fa);
    req = "R10"; cmd(4, 0); cmd(9, 0); cmd(3, 0); cmd(10, 0); cmd(9, 16'h7ff);

    req = "R12"; cmd(1, 3, 4'hE, 0);
    step(); host_wr = 1'b1; host_wdata = 16'h0800 | 16'h0001;
    step(); host_wr = 1'b0; idle(BUSY); cmd(1, 4, 4'hE, 1); cmd(4, 0, 4'hE, BUSY);

    req = "R13"; cmd(2, 16'h7ff); cmd(31, 16'h7ff); cmd(7, 16'h0fe);

    req = "R11"; pulse(7'b0010000); cmd(16, 3);
    step(); host_wr = 1'b1; host_wdata = 16'h0000; evt_in = 7'b0000010;
    step(); host_wr = 1'b0; evt_in = 7'h0; idle(BUSY + 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule